// File: doc/BRIEF.md
# Event-Period Oscillator Trim Controller

This block estimates the error of the local clock by timestamping an external event whose period is known (for example a mains-derived pulse) and nudges a 6-bit trim code toward the correct frequency. A free-running counter runs on the local clock. Each rising edge of the synchronized event input latches the counter value. From the second latch onward, the previous timestamp is subtracted from the new one, which gives the number of local clocks in one event period.

That measured period is compared with an expected period and a tolerance margin, both supplied as inputs. If the count is above the expected value plus the margin, the local clock is fast and the trim code goes down by one. If the count is below the expected value minus the margin, the local clock is slow and the trim code goes up by one. Otherwise the trim code is left alone. The measured period is also presented on its own output, with a one-cycle strobe each time a new value is available.

Control is a three-state machine. `ST_IDLE` is entered from any state when `enable` is low, and captures are ignored there. From `ST_IDLE` with `enable` high, a capture edge stores a first timestamp and moves to `ST_TRACK`. Without a capture edge it moves to `ST_ARM`. `ST_ARM` waits for its first capture, stores the timestamp and moves to `ST_TRACK`. In `ST_TRACK` every capture measures a period, updates the trim code and refreshes the stored timestamp.

Top module: `evt_period_trim`

## Requirements
- R1: While reset is asserted and after its release, `trim_code` is 32 (parameter `TRIM_INIT`), `period_out` is 0 and `period_valid` is 0.
- R2: The event input passes through a two-flop synchronizer. A capture happens on a 0-to-1 transition of the synchronized signal. If `event_in` is first sampled high at clock edge k, then `period_valid` is high for exactly the one cycle following edge k+2, and `trim_code`/`period_out` take their new values at that edge.
- R3: The first capture after reset, or after `enable` returns high, only stores a timestamp. It raises no `period_valid` and changes neither `trim_code` nor `period_out`.
- R4: On each later capture, `period_out` becomes the number of clock edges between the two captures. `period_out` holds its value whenever `period_valid` is low.
- R5: A measured period strictly greater than `expected_period + margin` decrements `trim_code` by one.
- R6: A measured period strictly less than `expected_period - margin` increments `trim_code` by one. When `margin` exceeds `expected_period`, no measurement increments the code.
- R7: A measured period inside the inclusive band `[expected_period - margin, expected_period + margin]` leaves `trim_code` unchanged.
- R8: `trim_code` saturates: it never goes below 0 or above 63, and never wraps between the two.
- R9: While `enable` is low, event edges cause no capture. `period_valid` stays low and `trim_code` and `period_out` hold.
- R10: The period is computed modulo 2^CNT_W, so a counter wraparound between two captures still yields the true period for periods below 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock being trimmed |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Enables capturing and trimming |
| event_in | input | 1 | Asynchronous reference event of known period |
| expected_period | input | CNT_W | Nominal event period in local clock cycles |
| margin | input | CNT_W | Allowed deviation before the trim moves |
| trim_code | output | TRIM_W | Current trim code (higher code = faster clock) |
| period_out | output | CNT_W | Last measured event period |
| period_valid | output | 1 | One-cycle strobe when `period_out` is refreshed |

## Verification
The assertions assume that `event_in` stays high and then low for at least two clocks per pulse. They also assume that `expected_period` and `margin` change only while no capture is pending, and that `enable` toggles away from a synchronizing edge. The stimulus meets these assumptions in the following way. Pulses are three clocks high and at least two clocks low, and all inputs are driven on the falling clock edge. Configuration and enable changes are made only after the previous event's capture has settled, in the long low phase between pulses.

// File: rtl/evt_trim_pkg.sv
package evt_trim_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_TRACK = 2'd2
    } trk_state_t;

    typedef enum logic [1:0] {
        ADJ_HOLD = 2'd0,
        ADJ_UP   = 2'd1,
        ADJ_DOWN = 2'd2
    } trim_adj_t;

endpackage

// File: rtl/evt_edge_sync.sv
module evt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[STAGES-1];
    end

    assign rise = chain_q[STAGES-1] & ~last_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R2

endmodule

// File: rtl/free_run_ctr.sv
module free_run_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count <= '0;
        else        count <= count + 1'b1;
    end
endmodule

// File: rtl/trim_decide.sv
module trim_decide
    import evt_trim_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int TRIM_W = 6
) (
    input  logic [CNT_W-1:0]  period,
    input  logic [CNT_W-1:0]  expected,
    input  logic [CNT_W-1:0]  margin,
    input  logic [TRIM_W-1:0] trim_cur,
    output trim_adj_t         adj,
    output logic [TRIM_W-1:0] trim_next
);
    localparam int EXT_W = CNT_W + 2;
    localparam logic [TRIM_W-1:0] TRIM_MAX = '1;

    logic signed [EXT_W-1:0] per_x;
    logic signed [EXT_W-1:0] hi_x;
    logic signed [EXT_W-1:0] lo_x;
    logic                    too_long;
    logic                    too_short;

    always_comb begin
        per_x     = $signed({2'b00, period});
        hi_x      = $signed({2'b00, expected}) + $signed({2'b00, margin});
        lo_x      = $signed({2'b00, expected}) - $signed({2'b00, margin});
        too_long  = per_x > hi_x;
        too_short = per_x < lo_x;
        if (too_long)       adj = ADJ_DOWN;
        else if (too_short) adj = ADJ_UP;
        else                adj = ADJ_HOLD;
        AST_BAND_EXCLUSIVE: assert (!(too_long && too_short)); // R7
    end

    always_comb begin
        trim_next = trim_cur;
        unique case (adj)
            ADJ_DOWN: trim_next = (trim_cur == '0) ? trim_cur : trim_cur - 1'b1;
            ADJ_UP:   trim_next = (trim_cur == TRIM_MAX) ? trim_cur : trim_cur + 1'b1;
            default:  trim_next = trim_cur;
        endcase
    end
endmodule

// File: rtl/evt_period_trim.sv
module evt_period_trim
    import evt_trim_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int TRIM_W      = 6,
    parameter int SYNC_STAGES = 2,
    parameter int TRIM_INIT   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              event_in,
    input  logic [CNT_W-1:0]  expected_period,
    input  logic [CNT_W-1:0]  margin,
    output logic [TRIM_W-1:0] trim_code,
    output logic [CNT_W-1:0]  period_out,
    output logic              period_valid
);
    localparam logic [TRIM_W-1:0] TRIM_MAX   = '1;
    localparam logic [TRIM_W-1:0] TRIM_RESET = TRIM_W'(TRIM_INIT);

    trk_state_t        state_q, state_d;
    logic              cap;
    logic [CNT_W-1:0]  count;
    logic [CNT_W-1:0]  prev_q;
    logic [CNT_W-1:0]  meas;
    logic [CNT_W-1:0]  period_q;
    logic              valid_q;
    logic [TRIM_W-1:0] trim_q;
    logic [TRIM_W-1:0] trim_nxt;
    trim_adj_t         adj;

    evt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(event_in), .rise(cap)
    );

    free_run_ctr #(.W(CNT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .count(count)
    );

    assign meas = count - prev_q;

    trim_decide #(.CNT_W(CNT_W), .TRIM_W(TRIM_W)) u_dec (
        .period(meas), .expected(expected_period), .margin(margin),
        .trim_cur(trim_q), .adj(adj), .trim_next(trim_nxt)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = !enable ? ST_IDLE : (cap ? ST_TRACK : ST_ARM);
            ST_ARM:   state_d = !enable ? ST_IDLE : (cap ? ST_TRACK : ST_ARM);
            ST_TRACK: state_d = !enable ? ST_IDLE : ST_TRACK;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath / outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q   <= '0;
            period_q <= '0;
            valid_q  <= 1'b0;
            trim_q   <= TRIM_RESET;
        end else begin
            valid_q <= 1'b0;
            if (enable && cap) begin
                unique case (state_q)
                    ST_IDLE, ST_ARM: begin
                        prev_q <= count;
                    end
                    ST_TRACK: begin
                        prev_q   <= count;
                        period_q <= meas;
                        valid_q  <= 1'b1;
                        trim_q   <= trim_nxt;
                    end
                    default: prev_q <= count;
                endcase
            end
        end
    end

    assign trim_code    = trim_q;
    assign period_out   = period_q;
    assign period_valid = valid_q;

    AST_TRIM_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (trim_q != $past(trim_q)) |-> valid_q); // R5
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> !valid_q); // R9
    AST_PERIOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_q |-> $stable(period_q)); // R4
    AST_NO_WRAP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (trim_q == TRIM_MAX) |=> (trim_q != '0)); // R8
    AST_NO_WRAP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (trim_q == '0) |=> (trim_q != TRIM_MAX)); // R8
    AST_FIRST_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_TRACK) |=> !valid_q); // R3

endmodule

// File: tb/sim_evt_period_trim.sv
module sim_evt_period_trim;
    localparam int CW   = 12;
    localparam int MASK = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          event_in = 1'b0;
    logic [CW-1:0] expected_period = CW'(100);
    logic [CW-1:0] margin = CW'(4);
    logic [5:0]    trim_code;
    logic [CW-1:0] period_out;
    logic          period_valid;

    int checks = 0;
    int failures = 0;

    // reference model state
    int h1, h2, h3, cyc, prev_ts, m_trim, m_per, m_val, per;
    bit have_prev;

    always #2 clk = ~clk;

    evt_period_trim #(.CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .event_in(event_in),
        .expected_period(expected_period), .margin(margin),
        .trim_code(trim_code), .period_out(period_out), .period_valid(period_valid)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural model: capture 2 edges after the rise is first sampled
    always @(posedge clk) begin
        if (!rst_n) begin
            h1 = 0; h2 = 0; h3 = 0; cyc = 0; prev_ts = 0;
            have_prev = 0; m_trim = 32; m_per = 0; m_val = 0;
        end else begin
            m_val = 0;
            if (!enable) begin
                have_prev = 0;
            end else if (h2 == 1 && h3 == 0) begin
                if (have_prev) begin
                    per   = (cyc - prev_ts) & MASK;
                    m_per = per;
                    m_val = 1;
                    if (per > int'(expected_period) + int'(margin)) begin
                        if (m_trim > 0) m_trim--;
                    end else if (per < int'(expected_period) - int'(margin)) begin
                        if (m_trim < 63) m_trim++;
                    end
                end
                prev_ts   = cyc;
                have_prev = 1;
            end
            h3 = h2; h2 = h1; h1 = int'(event_in);
            cyc++;
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 period_valid", int'(period_valid), m_val);
            chk("R4 period_out", int'(period_out), m_per);
            chk("R5 trim_code", int'(trim_code), m_trim);
        end
    end

    task automatic send_event(input int p);
        event_in = 1'b1;
        repeat (3) @(negedge clk);
        event_in = 1'b0;
        repeat (p - 3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 trim reset", int'(trim_code), 32);
        chk("R1 period reset", int'(period_out), 0);
        chk("R1 valid reset", int'(period_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 trim after release", int'(trim_code), 32);
        enable = 1'b1;
        @(negedge clk);

        send_event(100);
        chk("R3 first capture trim", int'(trim_code), 32);
        chk("R3 first capture period", int'(period_out), 0);
        send_event(104);            // measures 100
        send_event(105);            // measures 104 (upper band edge)
        chk("R7 upper edge holds", int'(trim_code), 32);
        send_event(96);             // measures 105
        chk("R5 too long decrements", int'(trim_code), 31);
        chk("R4 period value", int'(period_out), 105);
        send_event(95);             // measures 96 (lower band edge)
        chk("R7 lower edge holds", int'(trim_code), 31);
        send_event(50);             // measures 95
        chk("R6 too short increments", int'(trim_code), 32);

        for (int i = 0; i < 40; i++) send_event(50);
        chk("R8 saturate high", int'(trim_code), 63);
        for (int i = 0; i < 71; i++) send_event(200);
        chk("R8 saturate low", int'(trim_code), 0);
        chk("R4 period 200", int'(period_out), 200);

        enable = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 3; i++) send_event(50);
        chk("R9 disabled trim hold", int'(trim_code), 0);
        chk("R9 disabled period hold", int'(period_out), 200);

        enable = 1'b1;
        @(negedge clk);
        send_event(50);
        chk("R3 re-enable first capture period", int'(period_out), 200);
        chk("R3 re-enable first capture trim", int'(trim_code), 0);
        send_event(5);              // measures 50 -> up
        chk("R6 increments after re-enable", int'(trim_code), 1);

        expected_period = CW'(10);
        margin          = CW'(20);
        send_event(100);            // measures 5, lower bound negative
        chk("R6 wide margin never increments", int'(trim_code), 1);
        chk("R4 period 5", int'(period_out), 5);

        expected_period = CW'(4000);
        margin          = CW'(8);
        send_event(4000);           // measures 100 -> up
        chk("R6 increment at 4000 expected", int'(trim_code), 2);
        send_event(4000);
        send_event(4003);
        send_event(20);
        chk("R10 wrapped period", int'(period_out), 4003);
        chk("R10 trim held in band", int'(trim_code), 2);
        repeat (10) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule